// File: doc/BRIEF.md
# Ping-Pong Output Gamma Curve

This block applies a piecewise-linear transfer curve to each of three colour channels of a pixel stream. The curve for every channel is a uniform array of 64 points. Each point holds a base value and a slope delta. The curve lives in one of two banks, A and B. Software fills the bank that is not in use while the pixel path keeps reading the other one. A single mode write then swaps the banks over, so a new curve never shows up half-loaded.

Loading goes through one data port with an auto-incrementing pointer. Software writes the index to set the start point. Each point then takes six successive writes, always in the same order: red base, green base, blue base, red delta, green delta, blue delta. A per-channel mask picks which channels actually store what is written. A memory power enable must be high for writes to land. The status output reports the active configuration, and a hint output names the bank that software should load next.

On the pixel side, the top bits of each 16-bit channel value select a point and the low bits form the interpolation fraction. The result is the base value plus the scaled delta, clipped to full scale.

Top module: `pingpong_gamma_lut`

## Requirements
- R1: After reset, statusOut is 0, outValid is 0, and the write pointer is at point 0, phase 0.
- R2: The mode register value 1 selects bank A and 2 selects bank B; 0 and any other value (3) select bypass. statusOut reports the decoded configuration with the same encoding: 0 bypass, 1 A, 2 B. A mode write takes effect for pixels presented after the edge that captures it.
- R3: wrSel picks the bank being written: 0 for bank A, 1 for bank B. A data write changes only the selected bank.
- R4: An index write sets the point pointer to idxVal and the phase to 0. Writing 0 restarts a table load from the first point.
- R5: Accepted data writes cycle through phases 0 to 5, which store red base, green base, blue base, red delta, green delta and blue delta, in that order. After phase 5 the point pointer increments, and it wraps from 63 to 0.
- R6: wrMask bit 0 enables red, bit 1 green and bit 2 blue; 7 enables all three. A write whose channel is masked stores nothing, but the phase still advances.
- R7: With pwrEn low, a data write is dropped: nothing is stored and neither the phase nor the pointer moves.
- R8: In bank mode, each channel output is min(65535, base[p] + ((delta[p] × f) >> 10)). Here p is the top 6 bits of the input and f is the low 10 bits. outValid and the outputs follow pixValid by two clock edges.
- R9: In bypass, each output equals its input, with the same two-edge latency.
- R10: nextSel is 1 (bank B) when the status is bypass or A, and 0 (bank A) when the status is B.
- R11: When an index write and a data write arrive in the same cycle, the index write wins and the data write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrEn | input | 1 | Curve memory power enable |
| wrSel | input | 1 | Bank to write: 0 A, 1 B |
| wrMask | input | 3 | Channel write mask, bit 0 red, bit 1 green, bit 2 blue |
| idxWr | input | 1 | Index write strobe |
| idxVal | input | 6 | Start point for the index write |
| dataWr | input | 1 | Data port write strobe |
| dataVal | input | 16 | Data port value |
| modeWr | input | 1 | Mode write strobe |
| modeVal | input | 2 | Mode value: 0 bypass, 1 A, 2 B |
| statusOut | output | 2 | Active configuration: 0 bypass, 1 A, 2 B |
| nextSel | output | 1 | Bank to load next: 0 A, 1 B |
| pixValid | input | 1 | Pixel input valid |
| pixR | input | 16 | Red input |
| pixG | input | 16 | Green input |
| pixB | input | 16 | Blue input |
| outValid | output | 1 | Pixel output valid |
| outR | output | 16 | Red output |
| outG | output | 16 | Green output |
| outB | output | 16 | Blue output |

## Verification
A pointer or phase that drifts by a single write does not stay hidden. It stores a value in the wrong channel, role or point, and the next lookup that hits that point shows a wrong output two edges after the pixel goes in. A wrong mode decode or a wrong bank choice shows up at once on statusOut and nextSel, and on the following pixel output. The bench compares every output, status and hint against its own model on every clock. Lookups land on loaded, masked, power-gated and wrapped points, so a corrupted entry surfaces at the first pixel that reads it.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int IN_W     = 16;
  localparam int PT_W     = 6;
  localparam int FRAC_W   = IN_W - PT_W;
  localparam int NUM_PTS  = 1 << PT_W;
  localparam int NUM_CH   = 3;
  localparam int NUM_BANK = 2;
  localparam int PHASES   = 2 * NUM_CH;
  localparam int PH_W     = $clog2(PHASES);
  localparam int CH_W     = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    LUT_OFF    = 2'd0,
    LUT_BANK_A = 2'd1,
    LUT_BANK_B = 2'd2
  } lutMode_e;

  typedef struct packed {
    logic              wrEn;
    logic              wrBank;
    logic [CH_W-1:0]   wrChan;
    logic              wrDelta;
    logic [PT_W-1:0]   wrPoint;
    logic [IN_W-1:0]   wrData;
    lutMode_e          rdMode;
  } lutCtl_t;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrEn,
  input  logic              wrSel,
  input  logic [NUM_CH-1:0] wrMask,
  input  logic              idxWr,
  input  logic [PT_W-1:0]   idxVal,
  input  logic              dataWr,
  input  logic [IN_W-1:0]   dataVal,
  input  logic              modeWr,
  input  logic [1:0]        modeVal,
  output lutCtl_t           ctl,
  output logic [1:0]        statusOut,
  output logic              nextSel
);
  logic [PH_W-1:0] phase;
  logic [PT_W-1:0] point;
  logic [1:0]      modeReg;
  logic            accept;
  logic [CH_W-1:0] chan;
  logic            isDelta;
  lutMode_e        modeDec;

  assign accept  = dataWr && pwrEn && !idxWr;
  assign isDelta = (phase >= PH_W'(NUM_CH));
  assign chan    = isDelta ? CH_W'(phase - PH_W'(NUM_CH)) : CH_W'(phase);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      point   <= '0;
      modeReg <= '0;
    end else begin
      if (idxWr) begin
        point <= idxVal;
        phase <= '0;
      end else if (accept) begin
        if (phase == PH_W'(PHASES - 1)) begin
          phase <= '0;
          point <= point + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (modeWr) modeReg <= modeVal;
    end
  end

  always_comb begin
    case (modeReg)
      2'd1:    modeDec = LUT_BANK_A;
      2'd2:    modeDec = LUT_BANK_B;
      default: modeDec = LUT_OFF;
    endcase
  end

  always_comb begin
    ctl.wrEn    = accept && wrMask[chan];
    ctl.wrBank  = wrSel;
    ctl.wrChan  = chan;
    ctl.wrDelta = isDelta;
    ctl.wrPoint = point;
    ctl.wrData  = dataVal;
    ctl.rdMode  = modeDec;
  end

  assign statusOut = modeDec;
  assign nextSel   = (modeDec == LUT_BANK_B) ? 1'b0 : 1'b1;

  // R2: status never reports the unused code
  a_r2_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    statusOut != 2'd3);

  // R4 / R11: index write restarts the sequence at the given point
  a_r4_index_load: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (phase == '0) && (point == $past(idxVal)));

  // R5: an accepted write mid-point steps the phase and holds the point
  a_r5_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    (accept && phase != PH_W'(PHASES - 1)) |=>
      (phase == $past(phase) + 1'b1) && $stable(point));

  // R7: writes with power off leave the pointer untouched
  a_r7_power_drop: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !pwrEn && !idxWr) |=> $stable(phase) && $stable(point));

  // R5: the phase stays within the six-write sequence
  a_r5_phase_range: assert property (@(posedge clk) disable iff (!rstN)
    phase < PH_W'(PHASES));
endmodule

// File: rtl/gamma_lut_dp.sv
module gamma_lut_dp
  import gamma_lut_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  lutCtl_t                      ctl,
  input  logic                         pixValid,
  input  logic [NUM_CH-1:0][IN_W-1:0]  pixIn,
  output logic                         outValid,
  output logic [NUM_CH-1:0][IN_W-1:0]  outPix
);
  localparam int PROD_W = IN_W + FRAC_W;

  logic [NUM_BANK-1:0][NUM_CH-1:0][IN_W-1:0] rdBase;
  logic [NUM_BANK-1:0][NUM_CH-1:0][IN_W-1:0] rdDelta;
  logic [NUM_BANK*NUM_CH-1:0]                wrVec;

  genvar b, c;
  generate
    for (b = 0; b < NUM_BANK; b++) begin : g_bank
      for (c = 0; c < NUM_CH; c++) begin : g_chan
        logic [IN_W-1:0] baseMem  [NUM_PTS];
        logic [IN_W-1:0] deltaMem [NUM_PTS];
        logic            hit;
        assign hit = ctl.wrEn && (ctl.wrBank == 1'(b)) && (ctl.wrChan == CH_W'(c));
        assign wrVec[b*NUM_CH + c] = hit;
        always_ff @(posedge clk) begin
          if (hit) begin
            if (ctl.wrDelta) deltaMem[ctl.wrPoint] <= ctl.wrData;
            else             baseMem[ctl.wrPoint]  <= ctl.wrData;
          end
        end
        assign rdBase[b][c]  = baseMem[pixIn[c][IN_W-1 -: PT_W]];
        assign rdDelta[b][c] = deltaMem[pixIn[c][IN_W-1 -: PT_W]];
      end
    end
  endgenerate

  // stage 1: table read
  logic                        s1Valid;
  logic                        s1Bypass;
  logic [NUM_CH-1:0][IN_W-1:0] s1Pix;
  logic [NUM_CH-1:0][IN_W-1:0] s1Base;
  logic [NUM_CH-1:0][IN_W-1:0] s1Delta;
  logic                        useB;

  assign useB = (ctl.rdMode == LUT_BANK_B);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Bypass <= 1'b1;
      s1Pix    <= '0;
      s1Base   <= '0;
      s1Delta  <= '0;
    end else begin
      s1Valid  <= pixValid;
      s1Bypass <= (ctl.rdMode == LUT_OFF);
      s1Pix    <= pixIn;
      s1Base   <= useB ? rdBase[1] : rdBase[0];
      s1Delta  <= useB ? rdDelta[1] : rdDelta[0];
    end
  end

  // stage 2: interpolate and clip
  logic [NUM_CH-1:0][IN_W-1:0] interp;
  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      logic [PROD_W-1:0] prod;
      logic [IN_W:0]     sum;
      prod = s1Delta[k] * {{IN_W{1'b0}}, s1Pix[k][FRAC_W-1:0]};
      sum  = {1'b0, s1Base[k]} + {1'b0, prod[PROD_W-1 -: IN_W]};
      interp[k] = sum[IN_W] ? {IN_W{1'b1}} : sum[IN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= s1Valid;
      outPix   <= s1Bypass ? s1Pix : interp;
    end
  end

  // R3: one array at most takes a write per cycle
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  // R8: valid travels through both stages
  a_r8_valid_pipe: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> outValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> !outValid);

  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chk
      // R8: interpolated result never drops below the point base
      a_r8_floor: assert property (@(posedge clk) disable iff (!rstN)
        (s1Valid && !s1Bypass) |=> outPix[c] >= $past(s1Base[c]));
    end
  endgenerate
endmodule

// File: rtl/pingpong_gamma_lut.sv
module pingpong_gamma_lut
  import gamma_lut_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrEn,
  input  logic              wrSel,
  input  logic [NUM_CH-1:0] wrMask,
  input  logic              idxWr,
  input  logic [PT_W-1:0]   idxVal,
  input  logic              dataWr,
  input  logic [IN_W-1:0]   dataVal,
  input  logic              modeWr,
  input  logic [1:0]        modeVal,
  output logic [1:0]        statusOut,
  output logic              nextSel,
  input  logic              pixValid,
  input  logic [IN_W-1:0]   pixR,
  input  logic [IN_W-1:0]   pixG,
  input  logic [IN_W-1:0]   pixB,
  output logic              outValid,
  output logic [IN_W-1:0]   outR,
  output logic [IN_W-1:0]   outG,
  output logic [IN_W-1:0]   outB
);
  lutCtl_t                     ctl;
  logic [NUM_CH-1:0][IN_W-1:0] pixVec;
  logic [NUM_CH-1:0][IN_W-1:0] outVec;

  assign pixVec = {pixB, pixG, pixR};
  assign outR   = outVec[0];
  assign outG   = outVec[1];
  assign outB   = outVec[2];

  gamma_lut_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pwrEn(pwrEn), .wrSel(wrSel), .wrMask(wrMask),
    .idxWr(idxWr), .idxVal(idxVal), .dataWr(dataWr), .dataVal(dataVal),
    .modeWr(modeWr), .modeVal(modeVal), .ctl(ctl),
    .statusOut(statusOut), .nextSel(nextSel)
  );

  gamma_lut_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixValid(pixValid), .pixIn(pixVec),
    .outValid(outValid), .outPix(outVec)
  );
endmodule

// File: tb/pingpong_gamma_lut_tb.sv
module pingpong_gamma_lut_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrEn = 1'b0, wrSel = 1'b0;
  logic [2:0] wrMask = 3'd7;
  logic idxWr = 1'b0;
  logic [5:0] idxVal = '0;
  logic dataWr = 1'b0;
  logic [15:0] dataVal = '0;
  logic modeWr = 1'b0;
  logic [1:0] modeVal = '0;
  logic [1:0] statusOut;
  logic nextSel;
  logic pixValid = 1'b0;
  logic [15:0] pixR = '0, pixG = '0, pixB = '0;
  logic outValid;
  logic [15:0] outR, outG, outB;

  always #2.5 clk = ~clk;

  pingpong_gamma_lut u_dut (
    .clk(clk), .rstN(rstN), .pwrEn(pwrEn), .wrSel(wrSel), .wrMask(wrMask),
    .idxWr(idxWr), .idxVal(idxVal), .dataWr(dataWr), .dataVal(dataVal),
    .modeWr(modeWr), .modeVal(modeVal), .statusOut(statusOut), .nextSel(nextSel),
    .pixValid(pixValid), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .outValid(outValid), .outR(outR), .outG(outG), .outB(outB)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R9";

  // behavioural model
  int mBase [2][3][64];
  int mDelta[2][3][64];
  int mPtr = 0, mPh = 0, mMode = 0;
  int s1V = 0, eV = 0;
  int s1Out[3];
  int eOut[3];

  function automatic int decMode(int m);
    return (m == 1 || m == 2) ? m : 0;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    int pix[3];
    int d;
    pix[0] = pixR; pix[1] = pixG; pix[2] = pixB;
    d = decMode(mMode);
    eV = s1V;
    for (int c = 0; c < 3; c++) eOut[c] = s1Out[c];
    s1V = pixValid;
    if (pixValid) begin
      for (int c = 0; c < 3; c++) begin
        if (d == 0) s1Out[c] = pix[c];
        else begin
          int bk, pt, fr, v;
          bk = d - 1;
          pt = pix[c] / 1024;
          fr = pix[c] % 1024;
          v = mBase[bk][c][pt] + ((mDelta[bk][c][pt] * fr) / 1024);
          s1Out[c] = (v > 65535) ? 65535 : v;
        end
      end
    end
    if (idxWr) begin
      mPtr = idxVal; mPh = 0;
    end else if (dataWr && pwrEn) begin
      int ch;
      ch = mPh % 3;
      if (wrMask[ch]) begin
        if (mPh < 3) mBase[wrSel][ch][mPtr] = dataVal;
        else         mDelta[wrSel][ch][mPtr] = dataVal;
      end
      mPh++;
      if (mPh == 6) begin mPh = 0; mPtr = (mPtr + 1) % 64; end
    end
    if (modeWr) mMode = modeVal;
  endtask

  task automatic tick();
    int d;
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    d = decMode(mMode);
    check(curReq, outValid, eV, "outValid");
    if (eV != 0) begin
      check(curReq, outR, eOut[0], "outR");
      check(curReq, outG, eOut[1], "outG");
      check(curReq, outB, eOut[2], "outB");
    end
    check("R2", statusOut, d, "statusOut");
    check("R10", nextSel, (d == 2) ? 0 : 1, "nextSel");
  endtask

  task automatic doIndex(int i);
    idxWr = 1'b1; idxVal = 6'(i); tick(); idxWr = 1'b0;
  endtask
  task automatic doData(int v);
    dataWr = 1'b1; dataVal = 16'(v); tick(); dataWr = 1'b0;
  endtask
  task automatic doMode(int m);
    modeWr = 1'b1; modeVal = 2'(m); tick(); modeWr = 1'b0;
  endtask
  task automatic doPix(int r, int g, int b);
    pixValid = 1'b1; pixR = 16'(r); pixG = 16'(g); pixB = 16'(b);
    tick(); pixValid = 1'b0;
  endtask
  task automatic drain();
    tick(); tick();
  endtask

  function automatic int baseOf(int bk, int ch, int p);
    if (p == 63) return 16'hFF00 + ch;
    return bk ? (p * 900 + 50 + ch * 11) : (p * 1000 + ch * 7);
  endfunction
  function automatic int deltaOf(int bk, int ch, int p);
    if (p == 63) return 16'hFFFF;
    return bk ? ((p * 211 + ch * 53) & 16'h7FFF) : ((p * 331 + ch * 97) & 16'hFFFF);
  endfunction

  task automatic loadBank(int bk);
    wrSel = 1'(bk); wrMask = 3'd7;
    doIndex(0);
    for (int p = 0; p < 64; p++) begin
      for (int c = 0; c < 3; c++) doData(baseOf(bk, c, p));
      for (int c = 0; c < 3; c++) doData(deltaOf(bk, c, p));
    end
  endtask

  task automatic probePoint(int p);
    doPix(p * 1024, p * 1024 + 1023, p * 1024 + 512);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int seed;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 3; c++)
        for (int p = 0; p < 64; p++) begin mBase[b][c][p] = 0; mDelta[b][c][p] = 0; end
    for (int c = 0; c < 3; c++) begin s1Out[c] = 0; eOut[c] = 0; end

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", outValid, 0, "outValid in reset");
    check("R1", statusOut, 0, "statusOut in reset");
    check("R1", nextSel, 1, "nextSel in reset");
    rstN = 1'b1;
    pwrEn = 1'b1;

    // R9: bypass passthrough, several patterns
    curReq = "R9";
    doPix(0, 65535, 12345);
    doPix(1023, 1024, 40000);
    pixValid = 1'b1; pixR = 16'd7; pixG = 16'd8; pixB = 16'd9; tick();
    pixR = 16'hAAAA; pixG = 16'h5555; pixB = 16'hFFFF; tick(); pixValid = 1'b0;
    drain();

    // R3, R4, R5: fill both banks through the data port
    curReq = "R5";
    loadBank(0);
    loadBank(1);

    // R8: bank A lookups, including clipping at point 63
    curReq = "R8";
    doMode(1);
    for (int p = 0; p < 64; p += 9) probePoint(p);
    probePoint(63);
    seed = 17;
    for (int i = 0; i < 40; i++) begin
      int r, g, b;
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF; r = seed & 16'hFFFF;
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF; g = seed & 16'hFFFF;
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF; b = seed & 16'hFFFF;
      doPix(r, g, b);
    end
    drain();

    // R3: bank B holds its own curve
    curReq = "R3";
    doMode(2);
    for (int p = 0; p < 64; p += 7) probePoint(p);
    drain();

    // R2: unused mode code behaves as bypass; mode and pixel in the same cycle
    curReq = "R2";
    doMode(3);
    doPix(4321, 60000, 100);
    modeWr = 1'b1; modeVal = 2'd1; pixValid = 1'b1; pixR = 16'd5000; pixG = 16'd6000; pixB = 16'd7000;
    tick(); modeWr = 1'b0;
    pixR = 16'd5000; tick(); pixValid = 1'b0;
    drain();

    // R7: power off drops writes and holds the pointer
    curReq = "R7";
    wrSel = 1'b0; wrMask = 3'd7;
    doIndex(5);
    pwrEn = 1'b0;
    for (int k = 0; k < 6; k++) doData(16'h1111 * (k + 1));
    pwrEn = 1'b1;
    probePoint(5);
    for (int k = 0; k < 6; k++) doData(300 + k * 5);
    probePoint(5); probePoint(6);
    drain();

    // R6: masked channels keep their values, phase still advances
    curReq = "R6";
    wrMask = 3'b010;
    doIndex(7);
    for (int k = 0; k < 6; k++) doData(20000 + k);
    wrMask = 3'd7;
    for (int k = 0; k < 6; k++) doData(30000 + k);
    probePoint(7); probePoint(8);
    drain();

    // R5: pointer wraps from 63 to 0
    curReq = "R5";
    doIndex(63);
    for (int k = 0; k < 12; k++) doData(1000 + k * 3);
    probePoint(63); probePoint(0); probePoint(1);
    drain();

    // R11 / R4: index write beats a concurrent data write
    curReq = "R11";
    idxWr = 1'b1; idxVal = 6'd10; dataWr = 1'b1; dataVal = 16'hBEEF; tick();
    idxWr = 1'b0; dataWr = 1'b0;
    for (int k = 0; k < 6; k++) doData(4000 + k * 100);
    probePoint(10); probePoint(11);
    drain();

    // R10: hint in every mode
    curReq = "R10";
    doMode(0); doMode(2); doMode(1);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule